// File: doc/BRIEF.md
# Watchdog and Reset Pulse Generator

This block drives an active-low, open-drain-style system reset. It pulls the line low for a fixed hold time after the chip reset, and during any period in which the supply comparator reports a low supply. It then keeps the line low for the full hold time once the supply has recovered. A pad outside the block turns a 0 on `reset_n` into a pull-down and a 1 into a released line.

A watchdog counter runs while reset is released. A host keeps it from expiring by issuing a start condition on the two-wire bus: SDA falls while SCL is high. Both bus lines are sampled raw and pass through two-flop synchronizers. If no start condition arrives within the selected interval, the block pulls reset low for the hold time and then releases it. A 2-bit select picks one of three preset intervals or turns the watchdog off. Every length is a parameter counted in clock cycles.

Top module: `wdt_reset_gen`

## Requirements
- R1: While `rst` is high, `reset_n` is 0.
- R2: After `rst` is sampled low, `reset_n` stays 0 and becomes 1 at the HOLD_CYC-th rising edge, counting the first edge that samples `rst` low as the first.
- R3: The first rising edge that samples `supply_ok` at 0 drives `reset_n` to 0. It stays 0 for as long as `supply_ok` is 0.
- R4: Once `supply_ok` returns to 1, `reset_n` becomes 1 at the HOLD_CYC-th rising edge that samples it at 1. A dip during this hold restarts the full hold.
- R5: `wd_sel` encodes the interval: 0 selects WD_SHORT_CYC, 1 selects WD_MID_CYC and 2 selects WD_LONG_CYC. Without bus start conditions, `reset_n` falls at the N-th rising edge after the edge at which it rose. N is the selected interval.
- R6: A watchdog expiry holds `reset_n` at 0 for HOLD_CYC rising edges. It then releases the line.
- R7: `wd_sel` = 3 disables the watchdog, so `reset_n` never falls except through R1 or R3.
- R8: A start condition is SDA going 1 to 0 while SCL is 1. It restarts the watchdog count from zero. With no further starts, `reset_n` falls at rising edge N+3, counted from the SDA fall at the pins.
- R9: Three bus events leave the watchdog count untouched: SDA falling while SCL is 0, SCL rising, and SDA rising while SCL is 1.
- R10: The watchdog count is held at zero while `reset_n` is 0. Each release therefore starts a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset (power applied) |
| supply_ok | input | 1 | Supply comparator flag, 1 = supply above trip level |
| scl_in | input | 1 | Raw SCL line of the two-wire bus |
| sda_in | input | 1 | Raw SDA line of the two-wire bus |
| wd_sel | input | 2 | Watchdog interval select: 0 short, 1 mid, 2 long, 3 off |
| reset_n | output | 1 | Active-low reset; 0 = pull line low, 1 = release |

## Verification
The bench measures exact edge counts for the hold time and for each interval. An off-by-one in either counter shows up as a pulse or interval one cycle too long or too short. Bus sequences that only resemble a start condition check that the detector does not confuse a data change or a stop condition with a restart. A detector that did would postpone the expiry, and the measured interval would be too long. A supply dip during the hold checks that the hold restarts and is not simply resumed. A long random run compares every cycle with a bench model that is built from the requirements. It mixes supply dips, select changes and bus toggling, so the race between a restart and an expiry in the same cycle is covered.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_SEL_SHORT = 2'd0,
    WD_SEL_MID   = 2'd1,
    WD_SEL_LONG  = 2'd2,
    WD_SEL_OFF   = 2'd3
  } wd_sel_e;
endpackage

// File: rtl/bus_start_det.sv
module bus_start_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic start_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh;
  logic [MSB:0] sda_sh;
  logic         sda_last;

  // Idle bus reads high, so synchronizers reset to 1 to avoid a false start.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      sda_last <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[MSB-1:0], scl_raw};
      sda_sh   <= {sda_sh[MSB-1:0], sda_raw};
      sda_last <= sda_sh[MSB];
    end
  end

  assign start_o = scl_sh[MSB] & sda_last & ~sda_sh[MSB];
endmodule

// File: rtl/reset_hold_timer.sv
module reset_hold_timer #(
  parameter int HOLD_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic trig_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok || trig_i) begin
      cnt    <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt == LAST) busy_o <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int SHORT_CYC = 2000,
  parameter int MID_CYC   = 4000,
  parameter int LONG_CYC  = 8000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hold_i,
  input  logic      kick_i,
  input  wd_sel_e   sel_i,
  output logic      fire_o,
  output logic      zero_o
);
  localparam int MAXA = (SHORT_CYC > MID_CYC) ? SHORT_CYC : MID_CYC;
  localparam int MAXC = (MAXA > LONG_CYC) ? MAXA : LONG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          off;

  always_comb begin
    off = 1'b0;
    unique case (sel_i)
      WD_SEL_SHORT: lim_m1 = CW'(SHORT_CYC - 1);
      WD_SEL_MID:   lim_m1 = CW'(MID_CYC - 1);
      WD_SEL_LONG:  lim_m1 = CW'(LONG_CYC - 1);
      default: begin
        lim_m1 = '0;
        off    = 1'b1;
      end
    endcase
  end

  // A restart in the same cycle as the terminal count wins; >= covers a select shrunk mid-count.
  assign fire_o = !hold_i && !kick_i && !off && (cnt >= lim_m1);
  assign zero_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || hold_i || kick_i || off || fire_o) cnt <= '0;
    else                                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen
  import wdt_pkg::*;
#(
  parameter int HOLD_CYC     = 1000,
  parameter int WD_SHORT_CYC = 2000,
  parameter int WD_MID_CYC   = 4000,
  parameter int WD_LONG_CYC  = 8000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] wd_sel,
  output logic       reset_n
);
  logic bus_start;
  logic wd_fire;
  logic wd_zero;
  logic holding;

  bus_start_det #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk     (clk),
    .rst     (rst),
    .scl_raw (scl_in),
    .sda_raw (sda_in),
    .start_o (bus_start)
  );

  reset_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .trig_i    (wd_fire),
    .busy_o    (holding)
  );

  watchdog_timer #(
    .SHORT_CYC (WD_SHORT_CYC),
    .MID_CYC   (WD_MID_CYC),
    .LONG_CYC  (WD_LONG_CYC)
  ) u_wd (
    .clk    (clk),
    .rst    (rst),
    .hold_i (holding),
    .kick_i (bus_start),
    .sel_i  (wd_sel_e'(wd_sel)),
    .fire_o (wd_fire),
    .zero_o (wd_zero)
  );

  assign reset_n = ~holding;
endmodule

// File: rtl/wdt_reset_gen_chk.sv
module wdt_reset_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic [1:0] wd_sel,
  input logic       reset_n,
  input logic       wd_fire,
  input logic       wd_kick,
  input logic       wd_zero
);
  // R3
  supply_low_pulls_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !reset_n);

  // R5
  expiry_pulls_chk: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> !reset_n);

  // R7
  off_no_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_n && supply_ok && wd_sel == 2'b11) |=> reset_n);

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wd_kick |=> wd_zero);

  // R10
  held_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !reset_n |=> wd_zero);
endmodule

bind wdt_reset_gen wdt_reset_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .wd_sel    (wd_sel),
  .reset_n   (reset_n),
  .wd_fire   (wd_fire),
  .wd_kick   (bus_start),
  .wd_zero   (wd_zero)
);

// File: tb/tb_wdt_reset_gen.sv
module tb_wdt_reset_gen;
  localparam int H  = 20;
  localparam int L0 = 40;
  localparam int L1 = 70;
  localparam int L2 = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sup = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [1:0] sel = 2'd3;
  logic       reset_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // reference model state
  bit m_valid = 1'b0;
  bit m_busy = 1'b1;
  int m_hc = 0, m_wd = 0;
  bit m_scl1 = 1, m_scl2 = 1, m_sda1 = 1, m_sda2 = 1, m_sdap = 1;

  always #5 clk = ~clk;

  wdt_reset_gen #(
    .HOLD_CYC(H), .WD_SHORT_CYC(L0), .WD_MID_CYC(L1), .WD_LONG_CYC(L2)
  ) dut (
    .clk(clk), .rst(rst), .supply_ok(sup), .scl_in(scl), .sda_in(sda),
    .wd_sel(sel), .reset_n(reset_n)
  );

  function automatic int lim(input logic [1:0] s);
    case (s)
      2'd0: return L0;
      2'd1: return L1;
      2'd2: return L2;
      default: return 0;
    endcase
  endfunction

  function automatic void finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    bit kick, off, fire, nb;
    int nwd;
    @(posedge clk);
    kick = m_scl2 && m_sdap && !m_sda2;
    off  = (sel == 2'd3);
    fire = !m_busy && !kick && !off && (m_wd >= lim(sel) - 1);
    nwd  = (rst || m_busy || kick || off || fire) ? 0 : m_wd + 1;
    nb   = m_busy;
    if (rst || !sup || fire) begin m_hc = 0; nb = 1'b1; end
    else if (m_busy) begin
      if (m_hc == H - 1) nb = 1'b0; else m_hc++;
    end
    if (rst) begin
      m_scl1 = 1; m_scl2 = 1; m_sda1 = 1; m_sda2 = 1; m_sdap = 1; m_valid = 1'b1;
    end else begin
      m_sdap = m_sda2; m_sda2 = m_sda1; m_sda1 = sda; m_scl2 = m_scl1; m_scl1 = scl;
    end
    m_busy = nb; m_wd = nwd;
    @(negedge clk);
    cyc++;
    if (m_valid)
      check(reset_n == !m_busy, "R5 R8 R10 model trace", int'(reset_n), int'(!m_busy));
  endtask

  // edges until reset_n shows target
  task automatic measure(input logic target, output int n);
    n = 0;
    do begin tick(); n++; end while (reset_n !== target && n < 1000);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog timeout across R1 to R10 actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n, lows, highs;
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R1
    repeat (4) tick();
    check(reset_n == 1'b0, "R1 reset state", int'(reset_n), 0);
    rst = 1'b0;
    measure(1'b1, n);
    check(n == H, "R2 power-on hold", n, H);

    // R7: disabled, no expiry over a long window
    lows = 0;
    for (int i = 0; i < 300; i++) begin tick(); if (!reset_n) lows++; end
    check(lows == 0, "R7 watchdog off", lows, 0);

    // R5 short interval, R6 pulse width
    sel = 2'd0;
    measure(1'b0, n); check(n == L0, "R5 short interval", n, L0);
    measure(1'b1, n); check(n == H, "R6 expiry pulse width", n, H);
    // R10 full interval after release
    measure(1'b0, n); check(n == L0, "R10 full interval after release", n, L0);
    measure(1'b1, n); check(n == H, "R6 second pulse", n, H);

    // R9: data change with SCL low, then SDA rise with SCL high: no restart
    scl = 1'b0; tick();
    sda = 1'b0; tick();
    scl = 1'b1; tick();
    sda = 1'b1; tick();
    measure(1'b0, n); check(n + 4 == L0, "R9 non-start bus events", n + 4, L0);
    measure(1'b1, n);

    // R8: start condition restarts count
    repeat (10) tick();
    sda = 1'b0; tick();
    scl = 1'b0; tick();
    sda = 1'b1; tick();
    scl = 1'b1;
    measure(1'b0, n); check(n + 3 == L0 + 3, "R8 start restarts watchdog", n + 3, L0 + 3);
    measure(1'b1, n);

    // R5 mid and long
    sel = 2'd1;
    measure(1'b0, n); check(n == L1, "R5 mid interval", n, L1);
    sel = 2'd2;
    measure(1'b1, n);
    measure(1'b0, n); check(n == L2, "R5 long interval", n, L2);
    measure(1'b1, n);

    // R3 / R4 supply dip
    sel = 2'd3;
    repeat (5) tick();
    sup = 1'b0; tick();
    check(reset_n == 1'b0, "R3 low supply asserts", int'(reset_n), 0);
    highs = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (reset_n) highs++; end
    check(highs == 0, "R3 held while supply low", highs, 0);
    sup = 1'b1;
    measure(1'b1, n); check(n == H, "R4 hold after supply return", n, H);

    // R4: dip in the middle of the hold restarts it
    sup = 1'b0; tick();
    sup = 1'b1; repeat (10) tick();
    sup = 1'b0; tick();
    sup = 1'b1;
    measure(1'b1, n); check(n == H, "R4 hold restarts on dip", n, H);

    // random phase against the model
    begin
      int low_left;
      low_left = 0;
      rst = 1'b1; repeat (3) tick(); rst = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        if (low_left > 0) begin
          low_left--;
          sup = (low_left == 0);
        end else if ($urandom_range(0, 499) == 0) begin
          sup = 1'b0;
          low_left = $urandom_range(1, 30);
        end
        if ($urandom_range(0, 299) == 0) sel = 2'($urandom_range(0, 3));
        rst = ($urandom_range(0, 2999) == 0);
        if ($urandom_range(0, 59) == 0) scl = ~scl;
        if ($urandom_range(0, 59) == 0) sda = ~sda;
        tick();
      end
    end
    finish_run();
  end
endmodule